// File: doc/BRIEF.md
# Eight-bit auto-reload interval timer

This block is an 8-bit up-counter with a small register-style control port: a mode register, a load register, a readable count, a sticky overflow flag and an interrupt enable. In interval mode the counter runs freely from 0x00 to 0xFF, wraps to 0x00 and sets the flag. In auto-reload mode each overflow restarts the count from the load value, so the overflow period is 256 minus the load value, from 1 to 256 count clocks.

The count clock comes from a free-running prescaler on the system clock, which offers seven divide ratios. A further select code counts edges of an external event pin instead. The pin passes through a two-flop synchronizer, and a polarity bit picks which edge counts. Software writes the load register to preset the counter at once in either mode. It clears the flag by writing 0 to it. The interrupt request output is high while the flag and the enable are both set.

Top module: `reload_timer_top`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0, the irq output is 0 and the mode readback is 0x00 (interval mode, select code 000).
- R2: In interval mode (mode bit 7 = 0), a count clock while the count is 0xFF sets the count to 0x00 and sets the overflow flag.
- R3: In auto-reload mode (mode bit 7 = 1), a count clock while the count is 0xFF loads the count from the load register and sets the flag. With load value L the overflow period is 256-L count clocks.
- R4: A load-register write puts the written value into the count on the next clock, in both modes.
- R5: Select codes 000 to 110 in mode bits [2:0] give one count clock every 2^(code+1) system clocks.
- R6: Select code 111 counts edges of the synchronized event pin. Mode bit 4 = 0 counts rising edges and mode bit 4 = 1 counts falling edges. Edges of the other polarity have no effect.
- R7: The overflow flag stays set until a flag write with data 0. A flag write with data 1 has no effect.
- R8: irq is 1 exactly when the overflow flag is 1 and the interrupt enable (mode bit 3) is 1.
- R9: When a load write and a count clock fall in the same cycle, the written value is kept and that count is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtPin | input | 1 | External event input, asynchronous to clk |
| modeWr | input | 1 | Write strobe for the mode register |
| modeData | input | 8 | Mode data: [7] reload, [4] falling edge, [3] irq enable, [2:0] clock select |
| loadWr | input | 1 | Write strobe for the load register (also presets the count) |
| loadData | input | 8 | Load value |
| flagWr | input | 1 | Write strobe for the overflow flag |
| flagData | input | 1 | Flag write data; 0 clears the flag |
| count | output | 8 | Live counter value |
| modeVal | output | 8 | Mode register readback, unused bits 0 |
| ovfFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The count port carries almost all of the state. A wrong reload source or a wrong wrap value shows up on the first count clock after 0xFF. A wrong prescaler tap changes the spacing between count steps within one period of that tap. A lost or doubled event edge moves the count away from the bench's model within a few cycles of the pulse. Flag and irq errors appear in the cycle after an overflow or a flag write. Random event trains and random load values in both modes pile up any off-by-one in the count or the flag, so a single comparison after each run exposes it.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  parameter int CNT_W = 8;
  parameter int SEL_W = 3;
  localparam int MODE_RELOAD  = 7;
  localparam int MODE_FALLING = 4;
  localparam int MODE_IRQEN   = 3;

  typedef struct packed {
    logic countEn;
    logic loadWr;
    logic reloadMode;
    logic flagClr;
    logic irqEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/reload_timer_ctrl.sv
module reload_timer_ctrl
  import reload_timer_pkg::*;
#(
  parameter int SEL_BITS = SEL_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtPin,
  input  logic         modeWr,
  input  logic [7:0]   modeData,
  input  logic         loadWr,
  input  logic         flagWr,
  input  logic         flagData,
  output logic [7:0]   modeVal,
  output ctrlStrobes_t st
);
  localparam int TAPS = (1 << SEL_BITS) - 1;
  localparam logic [SEL_BITS-1:0] EXT_SEL = TAPS[SEL_BITS-1:0];

  logic                reloadMode, fallingSel, irqEn;
  logic [SEL_BITS-1:0] clkSel;
  logic [TAPS-1:0]     presc, prescPrev, tapPulse;
  logic [2:0]          syncPipe;
  logic                riseEv, fallEv, extEdge, tapEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadMode <= 1'b0;
      fallingSel <= 1'b0;
      irqEn      <= 1'b0;
      clkSel     <= '0;
    end else if (modeWr) begin
      reloadMode <= modeData[MODE_RELOAD];
      fallingSel <= modeData[MODE_FALLING];
      irqEn      <= modeData[MODE_IRQEN];
      clkSel     <= modeData[SEL_BITS-1:0];
    end
  end

  always_comb begin
    modeVal = '0;
    modeVal[MODE_RELOAD]    = reloadMode;
    modeVal[MODE_FALLING]   = fallingSel;
    modeVal[MODE_IRQEN]     = irqEn;
    modeVal[SEL_BITS-1:0]   = clkSel;
  end

  // free-running prescaler; every increment raises exactly one bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc     <= '0;
      prescPrev <= '0;
    end else begin
      presc     <= presc + 1'b1;
      prescPrev <= presc;
    end
  end

  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign tapPulse[k] = presc[k] & ~prescPrev[k];
    end
  endgenerate

  // two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[1:0], evtPin};
  end

  assign riseEv  = syncPipe[1] & ~syncPipe[2];
  assign fallEv  = ~syncPipe[1] & syncPipe[2];
  assign extEdge = fallingSel ? fallEv : riseEv;

  always_comb begin
    tapEn = 1'b0;
    for (int i = 0; i < TAPS; i++)
      if (clkSel == i[SEL_BITS-1:0]) tapEn = tapPulse[i];
  end

  always_comb begin
    st.countEn    = (clkSel == EXT_SEL) ? extEdge : tapEn;
    st.loadWr     = loadWr;
    st.reloadMode = reloadMode;
    st.flagClr    = flagWr & ~flagData;
    st.irqEn      = irqEn;
  end

  // R5
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tapPulse));

  // R6
  ext_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == EXT_SEL && st.countEn && !modeWr) |=> !st.countEn);
endmodule

// File: rtl/reload_timer_dp.sv
module reload_timer_dp
  import reload_timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t st,
  input  logic [W-1:0] loadData,
  output logic [W-1:0] count,
  output logic         ovfFlag,
  output logic         irq
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt, loadReg;
  logic         flag, overflow;

  assign overflow = st.countEn & ~st.loadWr & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      loadReg <= '0;
    end else begin
      if (st.loadWr) loadReg <= loadData;
      if (st.loadWr)
        cnt <= loadData;
      else if (st.countEn)
        cnt <= (cnt == CNT_MAX) ? (st.reloadMode ? loadReg : '0) : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           flag <= 1'b0;
    else if (overflow)   flag <= 1'b1;
    else if (st.flagClr) flag <= 1'b0;
  end

  assign count   = cnt;
  assign ovfFlag = flag;
  assign irq     = flag & st.irqEn;

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.loadWr |=> cnt == $past(loadData));

  // R2
  interval_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.countEn && !st.loadWr && !st.reloadMode && cnt == CNT_MAX) |=> (cnt == '0 && flag));

  // R3
  reload_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.countEn && !st.loadWr && st.reloadMode && cnt == CNT_MAX) |=> (cnt == $past(loadReg) && flag));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !st.flagClr) |=> flag);

  // R9
  no_count_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadWr && st.countEn) |=> !$rose(flag));
endmodule

// File: rtl/reload_timer_top.sv
module reload_timer_top
  import reload_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtPin,
  input  logic       modeWr,
  input  logic [7:0] modeData,
  input  logic       loadWr,
  input  logic [7:0] loadData,
  input  logic       flagWr,
  input  logic       flagData,
  output logic [7:0] count,
  output logic [7:0] modeVal,
  output logic       ovfFlag,
  output logic       irq
);
  ctrlStrobes_t st;

  reload_timer_ctrl #(.SEL_BITS(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtPin(evtPin), .modeWr(modeWr), .modeData(modeData),
    .loadWr(loadWr), .flagWr(flagWr), .flagData(flagData), .modeVal(modeVal), .st(st)
  );

  reload_timer_dp #(.W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .loadData(loadData),
    .count(count), .ovfFlag(ovfFlag), .irq(irq)
  );

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ovfFlag && modeVal[MODE_IRQEN]));
endmodule

// File: tb/tb_reload_timer_top.sv
module tb_reload_timer_top;
  logic clk = 0, rstN = 0, evtPin = 0;
  logic modeWr = 0, loadWr = 0, flagWr = 0, flagData = 0;
  logic [7:0] modeData = 0, loadData = 0;
  logic [7:0] count, modeVal;
  logic ovfFlag, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reload_timer_top dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setMode(input logic [7:0] m);
    @(negedge clk); modeWr = 1; modeData = m;
    @(negedge clk); modeWr = 0;
  endtask

  task automatic writeLoad(input logic [7:0] v);
    @(negedge clk); loadWr = 1; loadData = v;
    @(negedge clk); loadWr = 0;
  endtask

  task automatic writeFlag(input logic v);
    @(negedge clk); flagWr = 1; flagData = v;
    @(negedge clk); flagWr = 0;
  endtask

  task automatic pulse();
    @(negedge clk); evtPin = 1;
    @(negedge clk);
    @(negedge clk); evtPin = 0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] stepCnt(input logic [7:0] c, input bit rl, input logic [7:0] ld);
    if (c == 8'hFF) return rl ? ld : 8'h00;
    return c + 8'h01;
  endfunction

  task automatic measure(input int code);
    logic [7:0] prev;
    int n;
    setMode(8'(code));
    prev = count;
    n = 0;
    while (count == prev && n < 400) begin @(negedge clk); n++; end
    prev = count;
    n = 0;
    while (count == prev && n < 400) begin @(negedge clk); n++; end
    check($sformatf("R5 sel %0d period", code), n, 1 << (code + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] expC, ld;
    bit expF, rl;
    int n;
    process::self().srandom(32'h1234);
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 count", count, 0);
    check("R1 flag", ovfFlag, 0);
    check("R1 irq", irq, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 mode", modeVal, 0);

    // R5 prescaler taps
    for (int k = 0; k < 7; k++) measure(k);

    // R4 load copies in interval mode, ext clock so nothing else counts
    setMode(8'h07);
    writeLoad(8'h5A);
    check("R4 interval load", count, 8'h5A);
    // R6 rising edges
    pulse(); settle();
    check("R6 rising count", count, 8'h5B);
    // R2 interval wrap
    writeLoad(8'hFE);
    pulse(); settle();
    check("R2 at FF", count, 8'hFF);
    check("R2 no flag yet", ovfFlag, 0);
    pulse(); settle();
    check("R2 wrap", count, 8'h00);
    check("R2 flag", ovfFlag, 1);
    // R8 irq gating
    check("R8 irq disabled", irq, 0);
    setMode(8'h0F);
    check("R8 irq enabled", irq, 1);
    // R7 flag write 1 ignored, write 0 clears
    writeFlag(1'b1);
    check("R7 write 1 keeps", ovfFlag, 1);
    writeFlag(1'b0);
    check("R7 write 0 clears", ovfFlag, 0);
    check("R8 irq drops", irq, 0);

    // R6 falling polarity: rising edge ignored
    setMode(8'h17);
    writeLoad(8'h10);
    @(negedge clk); evtPin = 1;
    settle();
    check("R6 rising ignored", count, 8'h10);
    @(negedge clk); evtPin = 0;
    settle();
    check("R6 falling counted", count, 8'h11);

    // R3 auto-reload, period 256-L
    setMode(8'h87);
    writeLoad(8'hFC);
    check("R4 reload-mode load", count, 8'hFC);
    repeat (3) pulse();
    settle();
    check("R3 before overflow", count, 8'hFF);
    check("R3 flag clear", ovfFlag, 0);
    pulse(); settle();
    check("R3 reload value", count, 8'hFC);
    check("R3 flag", ovfFlag, 1);
    writeFlag(1'b0);
    writeLoad(8'hFF);
    pulse(); settle();
    check("R3 L=FF stays", count, 8'hFF);
    check("R3 L=FF flag", ovfFlag, 1);
    writeFlag(1'b0);

    // R9 load write in the same cycle as an event count
    setMode(8'h07);
    writeLoad(8'h20);
    @(negedge clk); evtPin = 1;
    @(negedge clk);
    @(negedge clk); loadWr = 1; loadData = 8'h77;
    @(negedge clk); loadWr = 0;
    check("R9 load wins", count, 8'h77);
    @(negedge clk); evtPin = 0;
    settle();
    check("R9 count dropped", count, 8'h77);

    // random event trains in both modes
    for (int it = 0; it < 30; it++) begin
      rl = $urandom_range(0, 1);
      ld = 8'($urandom_range(0, 255));
      setMode(rl ? 8'h87 : 8'h07);
      writeFlag(1'b0);
      writeLoad(ld);
      expC = ld;
      expF = 0;
      n = $urandom_range(0, 140);
      for (int p = 0; p < n; p++) begin
        pulse();
        if (expC == 8'hFF) expF = 1;
        expC = stepCnt(expC, rl, ld);
      end
      settle();
      check($sformatf("%s random count", rl ? "R3" : "R2"), count, expC);
      check("R7 random flag", ovfFlag, expF);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule